// File: doc/BRIEF.md
# Four-Phase Handshake Byte-Bus Target

This block is the target end of an 8-bit parallel link from a microcontroller. The host drives four asynchronous control lines: an active-low reset, a start pulse, a direction select, and a request strobe. The target brings all four into its own clock domain. It answers every byte with its own handshake-out line, and it keeps an acknowledge line high for the whole of each transaction. The bidirectional data pins are split into an input byte, an output byte and an output enable, so the pad ring can build the tristate buffer.

A transaction is opened by a start pulse. The host then sends a six-byte request: a command byte, a register address byte, and a 32-bit data word with the least significant byte first. The target decodes the request into at most one single-cycle strobe on a generic register port. It then returns an eight-byte reply: the read data word, then a status word, each with the least significant byte first. After the last reply byte the target drops acknowledge and goes back to idle.

Command 0x01 writes a register and command 0x02 reads one. The status code is 0 for success, 1 for an unknown command and 2 for an address at or above the register count.

Top module: `hsk_byte_target`

## Requirements
- R1: While the system reset or the host reset line is low, tgt_ack, tgt_hsk, bus_oe, reg_wr_en and reg_rd_en are all 0.
- R2: A rising edge on the synchronised start line while idle raises tgt_ack. tgt_ack stays high until the host lowers its request after the eighth reply byte, and then returns to 0.
- R3: For each request byte, with direction low (write), the target raises tgt_hsk only after it sees the request high. It lowers tgt_hsk once it sees the request low again.
- R4: Request bytes arrive in this order: byte 0 is the command, byte 1 is the address, bytes 2 to 5 are the data word with the least significant byte first. The address appears on reg_addr and the data word on reg_wdata.
- R5: A command of 0x01 with an address below NUM_REGS produces exactly one single-cycle reg_wr_en pulse and no read strobe. The reply carries data 0 and status 0.
- R6: A command of 0x02 with an address below NUM_REGS produces exactly one single-cycle reg_rd_en pulse. The reply data is reg_rdata as sampled on the cycle after the strobe, and the status is 0.
- R7: Any command other than 0x01 or 0x02 produces no strobe, reply data 0 and status 1. This holds whatever the address is.
- R8: A valid command with an address of NUM_REGS or above produces no strobe, reply data 0 and status 2.
- R9: The reply is eight bytes: the data word, then the status word, each with the least significant byte first. For each byte the target drives it and raises tgt_hsk. It lowers tgt_hsk after the request goes high, and it moves on after the request goes low.
- R10: bus_oe is high only while the direction line reads 1 (read) during the reply phase. It is never high during the request phase.
- R11: Pulling the host reset line low in the middle of a transaction returns the target to idle with no strobe issued. The next transaction completes normally.
- R12: Start pulses that arrive while a transaction is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | System reset, asynchronous, active low |
| host_rst_n_a | input | 1 | Host reset line, asynchronous, active low |
| host_start_a | input | 1 | Host start pulse, asynchronous |
| host_rnw_a | input | 1 | Host direction select, 1 = target drives the bus |
| host_req_a | input | 1 | Host handshake-in strobe, asynchronous |
| bus_in | input | BUS_W | Data byte from the pins |
| bus_out | output | BUS_W | Data byte toward the pins |
| bus_oe | output | 1 | Pin output enable |
| tgt_hsk | output | 1 | Target handshake-out |
| tgt_ack | output | 1 | Transaction busy acknowledge |
| reg_wr_en | output | 1 | Register write strobe, one cycle |
| reg_rd_en | output | 1 | Register read strobe, one cycle |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | WORD_W | Register write data |
| reg_rdata | input | WORD_W | Register read data, valid the cycle after reg_rd_en |

## Verification
Directed transactions cover the edges of the address space: index 0, the last valid index, the first invalid index and the highest byte value. They also pair an unknown command with a bad address, which shows whether the command check takes priority over the range check. A seeded random mix of writes, reads and random command bytes, with addresses that straddle the limit, is scored against a mirror of the register contents. Each read therefore tells a correct byte order and data path apart from stale or shuffled data. Two more cases test robustness: a stray start pulse partway through a request, and a host reset partway through, followed by a clean transaction.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX_HI,
      ST_RX_LO,
      ST_EXEC,
      ST_CAPT,
      ST_TX_DRV,
      ST_TX_HI,
      ST_TX_LO
   } hsk_state_e;

   localparam logic [7:0] OP_WRITE = 8'h01;
   localparam logic [7:0] OP_READ  = 8'h02;

   localparam int unsigned STS_OK       = 0;
   localparam int unsigned STS_BAD_CMD  = 1;
   localparam int unsigned STS_BAD_ADDR = 2;

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
   parameter int              WIDTH     = 4,
   parameter int              STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_a,
   output logic [WIDTH-1:0] q_s
);

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RESET_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_a};
      end
   end

   assign q_s = chain_q[STAGES-1];

endmodule

// File: rtl/hsk_decode.sv
module hsk_decode
   import hsk_pkg::*;
#(
   parameter int BUS_W    = 8,
   parameter int WORD_W   = 32,
   parameter int NUM_REGS = 64
) (
   input  logic [BUS_W-1:0]  cmd_byte,
   input  logic [BUS_W-1:0]  addr_byte,
   output logic              do_wr,
   output logic              do_rd,
   output logic [WORD_W-1:0] status
);

   localparam int ADDR_SPAN = 2 ** BUS_W;

   logic addr_ok;
   logic is_wr;
   logic is_rd;

   generate
      if (NUM_REGS >= ADDR_SPAN) begin : g_full_span
         assign addr_ok = 1'b1;
      end else begin : g_range_cmp
         localparam logic [BUS_W:0] LIMIT = (BUS_W+1)'(NUM_REGS);
         assign addr_ok = ({1'b0, addr_byte} < LIMIT);
      end
   endgenerate

   assign is_wr = (cmd_byte == BUS_W'(OP_WRITE));
   assign is_rd = (cmd_byte == BUS_W'(OP_READ));

   always_comb begin
      do_wr  = 1'b0;
      do_rd  = 1'b0;
      status = WORD_W'(STS_OK);
      if (!(is_wr || is_rd)) begin
         status = WORD_W'(STS_BAD_CMD);
      end else if (!addr_ok) begin
         status = WORD_W'(STS_BAD_ADDR);
      end else begin
         do_wr = is_wr;
         do_rd = is_rd;
      end
   end

endmodule

// File: rtl/hsk_engine.sv
module hsk_engine
   import hsk_pkg::*;
#(
   parameter int BUS_W  = 8,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hrst_s,
   input  logic              start_rise,
   input  logic              rnw_s,
   input  logic              req_s,
   input  logic [BUS_W-1:0]  bus_in,
   input  logic              do_wr,
   input  logic              do_rd,
   input  logic [WORD_W-1:0] status,
   input  logic [WORD_W-1:0] reg_rdata,
   output logic [BUS_W-1:0]  cmd_byte,
   output logic [BUS_W-1:0]  addr_byte,
   output logic [WORD_W-1:0] wdata,
   output logic              reg_wr_en,
   output logic              reg_rd_en,
   output logic [BUS_W-1:0]  bus_out,
   output logic              bus_oe,
   output logic              tgt_hsk,
   output logic              tgt_ack
);

   localparam int WORD_BYTES = WORD_W / BUS_W;
   localparam int REQ_BYTES  = 2 + WORD_BYTES;
   localparam int RSP_BYTES  = 2 * WORD_BYTES;
   localparam int MAX_BYTES  = (REQ_BYTES > RSP_BYTES) ? REQ_BYTES : RSP_BYTES;
   localparam int CNT_W      = $clog2(MAX_BYTES);
   localparam logic [CNT_W-1:0] REQ_LAST = CNT_W'(REQ_BYTES - 1);
   localparam logic [CNT_W-1:0] RSP_LAST = CNT_W'(RSP_BYTES - 1);

   hsk_state_e                  state_q;
   logic [CNT_W-1:0]            cnt_q;
   logic [REQ_BYTES*BUS_W-1:0]  rx_q;
   logic [RSP_BYTES*BUS_W-1:0]  rsp_q;
   logic [BUS_W-1:0]            out_q;
   logic                        hsk_q;
   logic                        ack_q;
   logic                        in_reply;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         rx_q    <= '0;
         rsp_q   <= '0;
         out_q   <= '0;
         hsk_q   <= 1'b0;
         ack_q   <= 1'b0;
      end else if (!hrst_s) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         rx_q    <= '0;
         rsp_q   <= '0;
         out_q   <= '0;
         hsk_q   <= 1'b0;
         ack_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_rise) begin
                  ack_q   <= 1'b1;
                  cnt_q   <= '0;
                  state_q <= ST_RX_HI;
               end
            end
            ST_RX_HI: begin
               if (req_s && !rnw_s) begin
                  rx_q[int'(cnt_q)*BUS_W +: BUS_W] <= bus_in;
                  hsk_q   <= 1'b1;
                  state_q <= ST_RX_LO;
               end
            end
            ST_RX_LO: begin
               if (!req_s) begin
                  hsk_q <= 1'b0;
                  if (cnt_q == REQ_LAST) begin
                     cnt_q   <= '0;
                     state_q <= ST_EXEC;
                  end else begin
                     cnt_q   <= cnt_q + 1'b1;
                     state_q <= ST_RX_HI;
                  end
               end
            end
            ST_EXEC: begin
               state_q <= ST_CAPT;
            end
            ST_CAPT: begin
               rsp_q   <= {status, (do_rd ? reg_rdata : {WORD_W{1'b0}})};
               state_q <= ST_TX_DRV;
            end
            ST_TX_DRV: begin
               if (rnw_s && !req_s) begin
                  out_q   <= rsp_q[int'(cnt_q)*BUS_W +: BUS_W];
                  hsk_q   <= 1'b1;
                  state_q <= ST_TX_HI;
               end
            end
            ST_TX_HI: begin
               if (req_s) begin
                  hsk_q   <= 1'b0;
                  state_q <= ST_TX_LO;
               end
            end
            ST_TX_LO: begin
               if (!req_s) begin
                  if (cnt_q == RSP_LAST) begin
                     cnt_q   <= '0;
                     ack_q   <= 1'b0;
                     state_q <= ST_IDLE;
                  end else begin
                     cnt_q   <= cnt_q + 1'b1;
                     state_q <= ST_TX_DRV;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign in_reply  = (state_q == ST_TX_DRV) || (state_q == ST_TX_HI) || (state_q == ST_TX_LO);
   assign cmd_byte  = rx_q[0 +: BUS_W];
   assign addr_byte = rx_q[BUS_W +: BUS_W];
   assign wdata     = rx_q[2*BUS_W +: WORD_W];
   assign reg_wr_en = (state_q == ST_EXEC) && do_wr;
   assign reg_rd_en = (state_q == ST_EXEC) && do_rd;
   assign bus_out   = out_q;
   assign bus_oe    = in_reply && rnw_s;
   assign tgt_hsk   = hsk_q;
   assign tgt_ack   = ack_q;

endmodule

// File: rtl/hsk_byte_target.sv
module hsk_byte_target #(
   parameter int BUS_W       = 8,
   parameter int WORD_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int NUM_REGS    = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_rst_n_a,
   input  logic              host_start_a,
   input  logic              host_rnw_a,
   input  logic              host_req_a,
   input  logic [BUS_W-1:0]  bus_in,
   output logic [BUS_W-1:0]  bus_out,
   output logic              bus_oe,
   output logic              tgt_hsk,
   output logic              tgt_ack,
   output logic              reg_wr_en,
   output logic              reg_rd_en,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [WORD_W-1:0] reg_wdata,
   input  logic [WORD_W-1:0] reg_rdata
);

   localparam int CTRL_W = 4;

   generate
      if (WORD_W % BUS_W != 0) begin : g_bad_word
         $error("WORD_W must be a whole number of bus bytes");
      end
      if (ADDR_W > BUS_W || ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must lie between 1 and BUS_W");
      end
      if (NUM_REGS < 1 || NUM_REGS > 2 ** ADDR_W) begin : g_bad_regs
         $error("NUM_REGS must fit the register address width");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (BUS_W < 8) begin : g_bad_bus
         $error("BUS_W must hold a command code");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_s;
   logic              hrst_s;
   logic              start_s;
   logic              rnw_s;
   logic              req_s;
   logic              start_q;
   logic              start_rise;
   logic [BUS_W-1:0]  cmd_byte;
   logic [BUS_W-1:0]  addr_byte;
   logic              do_wr;
   logic              do_rd;
   logic [WORD_W-1:0] status;

   hsk_sync #(
      .WIDTH     (CTRL_W),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL ('0)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_a   ({host_rst_n_a, host_start_a, host_rnw_a, host_req_a}),
      .q_s   (ctrl_s)
   );

   assign {hrst_s, start_s, rnw_s, req_s} = ctrl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
      end else begin
         start_q <= start_s;
      end
   end

   assign start_rise = start_s && !start_q;

   hsk_decode #(
      .BUS_W    (BUS_W),
      .WORD_W   (WORD_W),
      .NUM_REGS (NUM_REGS)
   ) u_decode (
      .cmd_byte  (cmd_byte),
      .addr_byte (addr_byte),
      .do_wr     (do_wr),
      .do_rd     (do_rd),
      .status    (status)
   );

   hsk_engine #(
      .BUS_W  (BUS_W),
      .WORD_W (WORD_W)
   ) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .hrst_s     (hrst_s),
      .start_rise (start_rise),
      .rnw_s      (rnw_s),
      .req_s      (req_s),
      .bus_in     (bus_in),
      .do_wr      (do_wr),
      .do_rd      (do_rd),
      .status     (status),
      .reg_rdata  (reg_rdata),
      .cmd_byte   (cmd_byte),
      .addr_byte  (addr_byte),
      .wdata      (reg_wdata),
      .reg_wr_en  (reg_wr_en),
      .reg_rd_en  (reg_rd_en),
      .bus_out    (bus_out),
      .bus_oe     (bus_oe),
      .tgt_hsk    (tgt_hsk),
      .tgt_ack    (tgt_ack)
   );

   assign reg_addr = addr_byte[ADDR_W-1:0];

endmodule

// File: rtl/hsk_byte_target_chk.sv
module hsk_byte_target_chk #(
   parameter int BUS_W    = 8,
   parameter int NUM_REGS = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hrst_s,
   input logic             rnw_s,
   input logic             req_s,
   input logic [BUS_W-1:0] addr_byte,
   input logic             reg_wr_en,
   input logic             reg_rd_en,
   input logic             bus_oe,
   input logic             tgt_hsk,
   input logic             tgt_ack
);

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({reg_wr_en, reg_rd_en})); // R5

   AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> !reg_wr_en); // R5

   AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_en |=> !reg_rd_en); // R6

   AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en || reg_rd_en) |-> (int'(addr_byte) < NUM_REGS)); // R8

   AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> rnw_s); // R10

   AST_HSK_IN_TXN: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_hsk |-> tgt_ack); // R3

   AST_RX_HSK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tgt_hsk) && !bus_oe) |-> $past(req_s)); // R3

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !tgt_ack |-> (!bus_oe && !tgt_hsk)); // R1

   AST_HOST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !hrst_s |=> (!tgt_ack && !reg_wr_en && !reg_rd_en)); // R11

   AST_ACK_FALL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tgt_ack) |-> !tgt_hsk); // R2

endmodule

bind hsk_byte_target hsk_byte_target_chk #(
   .BUS_W    (BUS_W),
   .NUM_REGS (NUM_REGS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hrst_s    (hrst_s),
   .rnw_s     (rnw_s),
   .req_s     (req_s),
   .addr_byte (addr_byte),
   .reg_wr_en (reg_wr_en),
   .reg_rd_en (reg_rd_en),
   .bus_oe    (bus_oe),
   .tgt_hsk   (tgt_hsk),
   .tgt_ack   (tgt_ack)
);

// File: tb/hsk_byte_target_tb.sv
`timescale 1ns/1ps
module hsk_byte_target_tb;

   localparam int NREG = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_rst_n_a = 1'b0;
   logic        host_start_a = 1'b0;
   logic        host_rnw_a = 1'b0;
   logic        host_req_a = 1'b0;
   logic [7:0]  bus_in = 8'h00;
   logic [7:0]  bus_out;
   logic        bus_oe;
   logic        tgt_hsk;
   logic        tgt_ack;
   logic        reg_wr_en;
   logic        reg_rd_en;
   logic [7:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;

   logic [31:0] mem [NREG];
   logic [31:0] model [NREG];
   int          wr_cnt = 0;
   int          rd_cnt = 0;
   logic [7:0]  last_addr = 8'h00;
   logic [31:0] last_wdata = 32'h0;
   int          n_checks = 0;
   int          n_err = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   hsk_byte_target u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_rst_n_a (host_rst_n_a),
      .host_start_a (host_start_a),
      .host_rnw_a   (host_rnw_a),
      .host_req_a   (host_req_a),
      .bus_in       (bus_in),
      .bus_out      (bus_out),
      .bus_oe       (bus_oe),
      .tgt_hsk      (tgt_hsk),
      .tgt_ack      (tgt_ack),
      .reg_wr_en    (reg_wr_en),
      .reg_rd_en    (reg_rd_en),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata)
   );

   // bench register bank: read data valid the cycle after the strobe
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) mem[i] <= 32'h0;
         reg_rdata <= 32'h0;
      end else begin
         reg_rdata <= mem[reg_addr[5:0]];
         if (reg_wr_en) mem[reg_addr[5:0]] <= reg_wdata;
      end
   end

   always @(posedge clk) begin
      if (reg_wr_en) begin
         wr_cnt     <= wr_cnt + 1;
         last_addr  <= reg_addr;
         last_wdata <= reg_wdata;
      end
      if (reg_rd_en) begin
         rd_cnt    <= rd_cnt + 1;
         last_addr <= reg_addr;
      end
   end

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic wait_hsk(input logic val, input string rq);
      int n = 0;
      while (tgt_hsk !== val && n < 300) begin
         @(negedge clk);
         n++;
      end
      chk(tgt_hsk === val, rq, 64'(tgt_hsk), 64'(val));
   endtask

   task automatic wait_ack(input logic val, input string rq);
      int n = 0;
      while (tgt_ack !== val && n < 300) begin
         @(negedge clk);
         n++;
      end
      chk(tgt_ack === val, rq, 64'(tgt_ack), 64'(val));
   endtask

   task automatic start_pulse();
      @(negedge clk);
      host_start_a = 1'b1;
      repeat (4) @(negedge clk);
      host_start_a = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      host_rnw_a = 1'b0;
      bus_in     = b;
      @(negedge clk);
      host_req_a = 1'b1;
      wait_hsk(1'b1, "R3 hsk rise on request byte");
      chk(bus_oe === 1'b0, "R10 oe low in request phase", 64'(bus_oe), 64'd0);
      host_req_a = 1'b0;
      wait_hsk(1'b0, "R3 hsk fall on request byte");
   endtask

   task automatic recv_byte(output logic [7:0] b);
      @(negedge clk);
      host_rnw_a = 1'b1;
      wait_hsk(1'b1, "R9 hsk rise on reply byte");
      chk(bus_oe === 1'b1, "R10 oe high in reply phase", 64'(bus_oe), 64'd1);
      b = bus_out;
      host_req_a = 1'b1;
      wait_hsk(1'b0, "R9 hsk fall on reply byte");
      host_req_a = 1'b0;
   endtask

   task automatic run_txn(input logic [7:0] cmd, input logic [7:0] addr, input logic [31:0] data,
                          input bit stray_start,
                          output logic [31:0] rsp_data, output logic [31:0] rsp_sts);
      logic [7:0]  req [6];
      logic [63:0] rsp;
      logic [7:0]  b;
      req[0] = cmd;
      req[1] = addr;
      for (int i = 0; i < 4; i++) req[2+i] = data[8*i +: 8];
      start_pulse();
      wait_ack(1'b1, "R2 ack rises after start");
      for (int i = 0; i < 6; i++) begin
         send_byte(req[i]);
         if (stray_start && i == 1) start_pulse();
      end
      rsp = 64'h0;
      for (int i = 0; i < 8; i++) begin
         if (i == 7) chk(tgt_ack === 1'b1, "R2 ack held before last reply byte", 64'(tgt_ack), 64'd1);
         recv_byte(b);
         rsp[8*i +: 8] = b;
      end
      @(negedge clk);
      host_rnw_a = 1'b0;
      wait_ack(1'b0, "R2 ack falls after reply");
      @(negedge clk);
      chk(bus_oe === 1'b0, "R10 oe low after direction returns", 64'(bus_oe), 64'd0);
      rsp_data = rsp[31:0];
      rsp_sts  = rsp[63:32];
   endtask

   function automatic logic [31:0] exp_status(input logic [7:0] cmd, input logic [7:0] addr);
      if (cmd != 8'h01 && cmd != 8'h02) return 32'd1;
      if (int'(addr) >= NREG) return 32'd2;
      return 32'd0;
   endfunction

   task automatic check_txn(input logic [7:0] cmd, input logic [7:0] addr, input logic [31:0] data,
                            input bit stray_start);
      logic [31:0] rd;
      logic [31:0] st;
      logic [31:0] es;
      logic [31:0] ed;
      int          w0;
      int          r0;
      string       tag;
      es = exp_status(cmd, addr);
      ed = (es == 0 && cmd == 8'h02) ? model[addr[5:0]] : 32'h0;
      if (es == 1) tag = "R7";
      else if (es == 2) tag = "R8";
      else if (cmd == 8'h01) tag = "R5";
      else tag = "R6";
      if (stray_start) tag = {tag, " R12"};
      w0 = wr_cnt;
      r0 = rd_cnt;
      run_txn(cmd, addr, data, stray_start, rd, st);
      chk(st === es, {tag, " status"}, 64'(st), 64'(es));
      chk(rd === ed, {tag, " R9 reply data"}, 64'(rd), 64'(ed));
      chk((wr_cnt - w0) == ((es == 0 && cmd == 8'h01) ? 1 : 0), {tag, " write strobes"},
          64'(wr_cnt - w0), 64'((es == 0 && cmd == 8'h01) ? 1 : 0));
      chk((rd_cnt - r0) == ((es == 0 && cmd == 8'h02) ? 1 : 0), {tag, " read strobes"},
          64'(rd_cnt - r0), 64'((es == 0 && cmd == 8'h02) ? 1 : 0));
      if (es == 0) chk(last_addr === addr, "R4 address byte", 64'(last_addr), 64'(addr));
      if (es == 0 && cmd == 8'h01) begin
         chk(last_wdata === data, "R4 data word order", 64'(last_wdata), 64'(data));
         model[addr[5:0]] = data;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_err++;
         $display("FAIL R2 watchdog: actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

   initial begin
      logic [7:0]  c;
      logic [7:0]  a;
      logic [31:0] d;
      int          w0;
      int          r0;
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < NREG; i++) model[i] = 32'h0;

      repeat (6) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      // R1: host reset still low
      chk(tgt_ack === 1'b0, "R1 ack in reset", 64'(tgt_ack), 64'd0);
      chk(tgt_hsk === 1'b0, "R1 hsk in reset", 64'(tgt_hsk), 64'd0);
      chk(bus_oe === 1'b0, "R1 oe in reset", 64'(bus_oe), 64'd0);
      chk({reg_wr_en, reg_rd_en} === 2'b00, "R1 strobes in reset", 64'({reg_wr_en, reg_rd_en}), 64'd0);
      host_rst_n_a = 1'b1;
      repeat (6) @(negedge clk);

      // directed corner cases
      check_txn(8'h01, 8'd0,   32'hA5A5_5A5A, 1'b0);
      check_txn(8'h02, 8'd0,   32'hFFFF_FFFF, 1'b0);
      check_txn(8'h01, 8'd63,  32'h0123_4567, 1'b0);
      check_txn(8'h02, 8'd63,  32'h0,         1'b0);
      check_txn(8'h01, 8'd64,  32'hDEAD_BEEF, 1'b0);
      check_txn(8'h02, 8'd255, 32'h0,         1'b0);
      check_txn(8'h00, 8'd5,   32'h1111_2222, 1'b0);
      check_txn(8'hFF, 8'd200, 32'h3333_4444, 1'b0);
      check_txn(8'h02, 8'd64,  32'h0,         1'b0);
      check_txn(8'h01, 8'd10,  32'h89AB_CDEF, 1'b1);
      check_txn(8'h02, 8'd10,  32'h0,         1'b1);

      // R11: host reset partway through a request
      w0 = wr_cnt;
      r0 = rd_cnt;
      start_pulse();
      wait_ack(1'b1, "R11 ack before abort");
      send_byte(8'h01);
      send_byte(8'd3);
      send_byte(8'h77);
      @(negedge clk);
      host_rst_n_a = 1'b0;
      repeat (6) @(negedge clk);
      chk(tgt_ack === 1'b0, "R11 ack cleared by host reset", 64'(tgt_ack), 64'd0);
      chk(tgt_hsk === 1'b0, "R11 hsk cleared by host reset", 64'(tgt_hsk), 64'd0);
      host_rst_n_a = 1'b1;
      repeat (6) @(negedge clk);
      chk((wr_cnt - w0) + (rd_cnt - r0) == 0, "R11 no strobe after abort",
          64'((wr_cnt - w0) + (rd_cnt - r0)), 64'd0);
      check_txn(8'h02, 8'd0, 32'h0, 1'b0);

      // seeded random mix
      for (int n = 0; n < 60; n++) begin
         int r;
         r = int'($urandom % 8);
         if (r < 4) c = 8'h01;
         else if (r < 7) c = 8'h02;
         else c = 8'($urandom);
         a = 8'($urandom % 80);
         d = $urandom;
         check_txn(c, a, d, 1'b0);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule